// File: doc/BRIEF.md
# Serial Memory Power-State Controller

This block tracks the power state of a serial memory device and tells the serial command front end which commands it may execute. After power-on reset it holds off all accesses for a fixed startup interval. Then it idles in standby, where every command is allowed. A decoded sleep command, once its chip-select frame closes, switches the regulators off. The block then runs a minimum entry interval and rests asleep.

While asleep only a wake command is honoured. Its frame close starts a recovery interval, and when that interval ends the block returns to standby. A chip-select frame opened during startup, entry or recovery is discarded. A power loss (reset) while asleep brings the block back through startup into standby.

All intervals are counted on a free-running reference clock. Their lengths are derived from the clock frequency in MHz and the interval lengths in microseconds. Chip select is assumed already synchronous to that clock. The command strobes are one-cycle pulses from the opcode decoder, raised while chip select is low.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While `rst_ni` is low, `busy_o`=1, `cmd_en_o`=0 and `reg_off_o`=0. After release, `cmd_en_o` goes high and `busy_o` goes low exactly STARTUP_CYC = CLK_MHZ*STARTUP_US rising clock edges later. Before that, `cmd_en_o` stays 0.
- R2: In standby, a `sleep_cmd_i` pulse seen while `cs_ni`=0 takes effect at the first clock edge that samples `cs_ni`=1. After that edge, `reg_off_o`=1, `busy_o`=1 and `cmd_en_o`=0.
- R3: The sleep entry interval lasts ENTRY_CYC = CLK_MHZ*ENTRY_US edges, counting the frame-close edge as the first. After it, `busy_o`=0 and `reg_off_o` stays 1, which is the asleep state.
- R4: While asleep, a chip-select frame that carries no wake strobe (no strobe, or a sleep strobe) leaves the block asleep.
- R5: While asleep, a `wake_cmd_i` pulse seen while `cs_ni`=0 takes effect at the frame-close edge. After that edge, `reg_off_o`=0 and `busy_o`=1. After RECOVER_CYC = CLK_MHZ*RECOVER_US edges the block is in standby, with `cmd_en_o`=1 and `busy_o`=0.
- R6: Frames and strobes that arrive during startup, entry or recovery are discarded. The interval lengths are unchanged, and no pending command survives into the next state.
- R7: A reset while asleep returns the block through the full startup interval into standby, not sleep.
- R8: In standby, a wake strobe has no effect, and strobes raised while `cs_ni`=1 have no effect in any state.
- R9: Exactly one of these holds at all times: standby (`cmd_en_o`), a timed interval (`busy_o`), or asleep (`reg_off_o` with `busy_o` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| cs_ni | input | 1 | Active-low chip select, synchronous to clk_i |
| sleep_cmd_i | input | 1 | One-cycle strobe: sleep opcode decoded |
| wake_cmd_i | input | 1 | One-cycle strobe: wake opcode decoded |
| cmd_en_o | output | 1 | Full command set may execute (standby) |
| reg_off_o | output | 1 | Regulators switched off (entry and sleep) |
| busy_o | output | 1 | A startup, entry or recovery timer is running |

## Verification
The bound checker watches every cycle for the following:
- the three outputs encode exactly one state;
- the regulators switch off or on only at a chip-select rising edge;
- the sleep and standby states are held until a frame closes;
- command enable rises only at the end of a busy interval.

Only the bench's scenarios can show the following:
- the exact lengths of the startup, entry and recovery intervals;
- that a frame opened inside a timed interval is discarded without stretching it;
- which strobe and chip-select combinations change state, which the bench sweeps across standby and sleep;
- that a reset taken while asleep lands in standby.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  typedef enum logic [2:0] {
    PS_BOOT,
    PS_IDLE,
    PS_ENTER,
    PS_DOZE,
    PS_RECOVER
  } pwr_state_e;
endpackage

// File: rtl/cs_rise_det.sv
module cs_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  output logic rise_o
);
  logic cs_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b1;
    else         cs_q <= cs_ni;
  end
  assign rise_o = cs_ni & ~cs_q;
endmodule

// File: rtl/cmd_pend.sv
// Holds a decoded strobe until the frame closes; cleared on every close.
module cmd_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic close_i,
  input  logic arm_sleep_i,
  input  logic arm_wake_i,
  output logic sleep_pend_o,
  output logic wake_pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_pend_o <= 1'b0;
      wake_pend_o  <= 1'b0;
    end else if (close_i) begin
      sleep_pend_o <= 1'b0;
      wake_pend_o  <= 1'b0;
    end else begin
      if (arm_sleep_i) sleep_pend_o <= 1'b1;
      if (arm_wake_i)  wake_pend_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/dwell_timer.sv
module dwell_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)            cnt_q <= val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int STARTUP_US = 400,
  parameter int ENTRY_US   = 3,
  parameter int RECOVER_US = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sleep_cmd_i,
  input  logic wake_cmd_i,
  output logic cmd_en_o,
  output logic reg_off_o,
  output logic busy_o
);
  localparam int STARTUP_CYC = CLK_MHZ * STARTUP_US;
  localparam int ENTRY_CYC   = CLK_MHZ * ENTRY_US;
  localparam int RECOVER_CYC = CLK_MHZ * RECOVER_US;
  localparam int MAX_A       = (STARTUP_CYC > ENTRY_CYC) ? STARTUP_CYC : ENTRY_CYC;
  localparam int MAX_CYC     = (MAX_A > RECOVER_CYC) ? MAX_A : RECOVER_CYC;
  localparam int CNT_W       = $clog2(MAX_CYC + 1);

  pwr_state_e       state_q, state_d;
  logic             close, sleep_pend, wake_pend, tmr_zero, tmr_load;
  logic [CNT_W-1:0] tmr_val;

  cs_rise_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .rise_o (close)
  );

  // strobes only arm in the state that may act on them
  cmd_pend u_pend (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .close_i      (close),
    .arm_sleep_i  (sleep_cmd_i & ~cs_ni & (state_q == PS_IDLE)),
    .arm_wake_i   (wake_cmd_i  & ~cs_ni & (state_q == PS_DOZE)),
    .sleep_pend_o (sleep_pend),
    .wake_pend_o  (wake_pend)
  );

  dwell_timer #(.CNT_W(CNT_W), .RST_VAL(STARTUP_CYC - 1)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      PS_BOOT:    if (tmr_zero) state_d = PS_IDLE;
      PS_IDLE:    if (close && sleep_pend) begin
                    state_d  = PS_ENTER;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(ENTRY_CYC - 1);
                  end
      PS_ENTER:   if (tmr_zero) state_d = PS_DOZE;
      PS_DOZE:    if (close && wake_pend) begin
                    state_d  = PS_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(RECOVER_CYC - 1);
                  end
      PS_RECOVER: if (tmr_zero) state_d = PS_IDLE;
      default:    state_d = PS_BOOT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_BOOT;
    else         state_q <= state_d;
  end

  always_comb begin
    cmd_en_o  = (state_q == PS_IDLE);
    reg_off_o = (state_q == PS_ENTER) || (state_q == PS_DOZE);
    busy_o    = (state_q == PS_BOOT) || (state_q == PS_ENTER) || (state_q == PS_RECOVER);
  end
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic cmd_en_o,
  input logic reg_off_o,
  input logic busy_o
);
  logic asleep;
  assign asleep = reg_off_o & ~busy_o;

  // R9: one-hot output state
  a_r9_one_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cmd_en_o, busy_o, asleep}) == 1);

  // R2: regulators switch off only on a frame close
  a_r2_off_on_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_off_o) |-> ($past(cs_ni) && !$past(cs_ni, 2)));

  // R5: regulators switch on only on a frame close, into recovery
  a_r5_on_on_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reg_off_o) |-> (busy_o && $past(cs_ni) && !$past(cs_ni, 2)));

  // R4: sleep held until a frame closes
  a_r4_sleep_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep && !(cs_ni && !$past(cs_ni))) |=> asleep);

  // R8: standby held until a frame closes
  a_r8_idle_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_en_o && !(cs_ni && !$past(cs_ni))) |=> cmd_en_o);

  // R1: command enable only after a timed interval
  a_r1_enable_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_en_o) |-> $past(busy_o));
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .cmd_en_o  (cmd_en_o),
  .reg_off_o (reg_off_o),
  .busy_o    (busy_o)
);

// File: tb/tb_pwr_state_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_state_ctrl;
  localparam int CLK_MHZ    = 2;
  localparam int STARTUP_US = 10;
  localparam int ENTRY_US   = 3;
  localparam int RECOVER_US = 8;
  localparam int N_ST = CLK_MHZ * STARTUP_US;
  localparam int N_EN = CLK_MHZ * ENTRY_US;
  localparam int N_RC = CLK_MHZ * RECOVER_US;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, slp = 1'b0, wk = 1'b0;
  logic cmd_en, reg_off, busy;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_state_ctrl #(.CLK_MHZ(CLK_MHZ), .STARTUP_US(STARTUP_US),
                   .ENTRY_US(ENTRY_US), .RECOVER_US(RECOVER_US)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sleep_cmd_i(slp),
    .wake_cmd_i(wk), .cmd_en_o(cmd_en), .reg_off_o(reg_off), .busy_o(busy));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // outputs packed as {cmd_en, reg_off, busy}
  task automatic chk_st(input string req, input int exp);
    chk(req, {29'd0, cmd_en, reg_off, busy}, exp);
  endtask

  localparam int S_IDLE = 3'b100, S_BUSY_ON = 3'b001, S_BUSY_OFF = 3'b011, S_SLEEP = 3'b010;

  task automatic frame(input bit s, input bit w, input bit active);
    @(negedge clk); cs_n = ~active;
    @(negedge clk); slp = s; wk = w;
    @(negedge clk); slp = 0; wk = 0;
    @(negedge clk); cs_n = 1'b1;
  endtask

  // negedges until busy is seen low, counting that one
  task automatic wait_idle(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (busy && n < 5000);
  endtask

  task automatic go_sleep();
    int m;
    frame(1, 0, 1); @(negedge clk); wait_idle(m);
  endtask

  task automatic go_wake();
    int m;
    frame(0, 1, 1); @(negedge clk); wait_idle(m);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk_st("R1 reset state", S_BUSY_ON);
    rst_n = 1'b1;
    wait_idle(n);
    chk("R1 startup length", n, N_ST);
    chk_st("R1 standby after startup", S_IDLE);

    // R2/R3/R5/R8 sweep in standby: strobe kind x chip-select activity
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 2; a++) begin
        bit exp_sleep;
        exp_sleep = k[0] && (a == 1);
        frame(k[0], k[1], a[0]);
        @(negedge clk);
        if (exp_sleep) begin
          chk_st("R2 entry on frame close", S_BUSY_OFF);
          wait_idle(n);
          chk("R3 entry length", n, N_EN);
          chk_st("R3 asleep after entry", S_SLEEP);
          frame(0, 1, 1); @(negedge clk);
          chk_st("R5 recovery on wake close", S_BUSY_ON);
          wait_idle(n);
          chk("R5 recovery length", n, N_RC);
          chk_st("R5 standby after recovery", S_IDLE);
        end else begin
          chk_st("R8 standby unaffected", S_IDLE);
        end
      end
    end

    // R4/R5/R8 sweep while asleep
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 2; a++) begin
        bit exp_wake;
        exp_wake = k[1] && (a == 1);
        go_sleep();
        chk_st("R3 asleep before sweep", S_SLEEP);
        frame(k[0], k[1], a[0]);
        @(negedge clk);
        if (exp_wake) begin
          chk_st("R5 wake accepted", S_BUSY_ON);
          wait_idle(n);
          chk("R5 recovery length sweep", n, N_RC);
        end else begin
          chk_st("R4 non-wake ignored asleep", S_SLEEP);
          repeat (3) @(negedge clk);
          chk_st("R4 still asleep", S_SLEEP);
          go_wake();
        end
        chk_st("R5 standby restored", S_IDLE);
      end
    end

    // R6: wake frame during entry is discarded
    frame(1, 0, 1); @(negedge clk);
    frame(0, 1, 1);
    wait_idle(n);
    chk("R6 entry length unchanged", n, N_EN - 4);
    chk_st("R6 still asleep after entry", S_SLEEP);
    repeat (4) @(negedge clk);
    chk_st("R6 no pending wake carried", S_SLEEP);

    // R6: sleep frame during recovery is discarded
    frame(0, 1, 1); @(negedge clk);
    frame(1, 0, 1);
    wait_idle(n);
    chk("R6 recovery length unchanged", n, N_RC - 4);
    chk_st("R6 standby after recovery", S_IDLE);
    repeat (4) @(negedge clk);
    chk_st("R6 no pending sleep carried", S_IDLE);

    // R7: power loss while asleep, plus a frame during startup (R6)
    go_sleep();
    chk_st("R7 asleep before reset", S_SLEEP);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk_st("R7 reset while asleep", S_BUSY_ON);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    frame(1, 0, 1);
    wait_idle(n);
    chk("R7 startup length after sleep", n, N_ST - 4);
    chk_st("R7 comes back in standby", S_IDLE);
    repeat (4) @(negedge clk);
    chk_st("R6 startup frame discarded", S_IDLE);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule